// File: doc/BRIEF.md
# Paced Double-Edge Transfer Receiver

This block is the receiving end of a paced, double-edge data phase. Each change of the incoming REQ line reaches it as a one-cycle event on `req_evt_i`, together with the 16-bit bus value and the level of the phase line `p1_i`. A rising REQ change and the falling change after it carry the two halves of one 32-bit group. The phase line behaves as follows:

- While data is good, `p1_i` changes level at the start of every pair.
- A pair that opens without that change reverses the valid/invalid sense.
- Only pairs classed as valid are packed into a word and presented for one cycle.

For every REQ change the block answers with one ACK change, subject to `ack_en_i`. It keeps a count of REQ changes not yet answered. It raises `done_o` once the counts balance and both lines are back low. Software or a sequencer pulses `start_i` at the beginning of a data phase, with REQ negated. That pulse declares the next pair valid and clears the sticky error flags.

Top module: `pt_rx`

## Requirements
- R1: After reset, `ack_o`, `word_vld_o`, `done_o`, `proto_err_o` and `ovf_o` are 0 and `pend_o` is 0. REQ is taken as negated.
- R2: While `ack_en_i` is 1 and `pend_o` is nonzero, `ack_o` inverts at each clock edge and `pend_o` drops by one. With one change outstanding, ACK inverts in the cycle after the REQ event.
- R3: `pend_o` counts REQ changes minus ACK changes. A REQ event raises it by one, and it does not move while `ack_en_i` is 0 and no event arrives.
- R4: `done_o` is 1 exactly when a phase has been started, `pend_o` is 0, and REQ and ACK are both negated.
- R5: For a valid pair, the first transfer appears in `word_o[31:16]` and the second in `word_o[15:0]`. `word_vld_o` is high for one cycle, the cycle after the second transfer's event.
- R6: The first pair after `start_i` is valid, whatever the level of `p1_i`.
- R7: A pair whose `p1_i` level differs from the previous pair's level keeps the previous classification. Invalid pairs produce no `word_vld_o`.
- R8: A pair whose `p1_i` level equals the previous pair's level flips the classification (valid to invalid, or invalid to valid).
- R9: A return from invalid to valid with no `p1_i` change inside the invalid stretch sets `proto_err_o`. The flag holds until `start_i`.
- R10: A REQ event arriving while `pend_o` equals MAX_PEND (15) and no ACK is issued in that cycle sets the sticky `ovf_o`. In that case `pend_o` stays at MAX_PEND.
- R11: Before the first `start_i`, REQ events are still counted and answered, but no word is produced and `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a data phase; next pair is valid |
| req_evt_i | input | 1 | One REQ change this cycle |
| data_i | input | 16 | Bus value at the REQ change |
| p1_i | input | 1 | Phase line level at the REQ change |
| ack_en_i | input | 1 | Allows an ACK change this cycle |
| ack_o | output | 1 | ACK line level |
| pend_o | output | 4 | REQ changes not yet answered |
| done_o | output | 1 | Counts balanced, both lines negated |
| word_o | output | 32 | Received group |
| word_vld_o | output | 1 | One-cycle strobe for `word_o` |
| proto_err_o | output | 1 | Sticky: invalid stretch had no phase change |
| ovf_o | output | 1 | Sticky: outstanding count overran |

## Verification
A wrong classification state shows up at the next pair. It appears as a missing or extra `word_vld_o` one cycle after that pair's second event, or as a spurious or absent `proto_err_o` one cycle after the pair's first event. A corrupt outstanding count or ACK level shows up on `pend_o`, `ack_o` and `done_o` in the very next cycle. The bench therefore compares these ports against its own model on every cycle, under random gaps, random ACK enable and random phase patterns.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic {
    PAIR_INVALID = 1'b0,
    PAIR_VALID   = 1'b1
  } pair_cls_e;

  function automatic pair_cls_e flip_cls(input pair_cls_e c);
    return (c == PAIR_VALID) ? PAIR_INVALID : PAIR_VALID;
  endfunction
endpackage

// File: rtl/pt_ack_tracker.sv
module pt_ack_tracker #(
  parameter int MAX_PEND = 15,
  parameter int CNT_W    = $clog2(MAX_PEND + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             req_evt_i,
  input  logic             req_lvl_n_i,
  input  logic             ack_en_i,
  output logic             ack_o,
  output logic [CNT_W-1:0] pend_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] PEND_MAX = CNT_W'(MAX_PEND);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] pend_q, pend_n;
  logic             ack_q, ack_n;
  logic             act_q, act_n;
  logic             ovf_q, ovf_n;
  logic             done_q;
  logic             fire, full_hit, inc;

  always_comb begin
    fire     = ack_en_i && (pend_q != '0);
    full_hit = req_evt_i && !fire && (pend_q == PEND_MAX);
    inc      = req_evt_i && !full_hit;
    pend_n   = pend_q;
    unique case ({inc, fire})
      2'b10:   pend_n = pend_q + ONE;
      2'b01:   pend_n = pend_q - ONE;
      default: pend_n = pend_q;
    endcase
    ack_n = ack_q ^ fire;
    act_n = act_q || start_i;
    ovf_n = (ovf_q && !start_i) || full_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ack_q  <= 1'b0;
      act_q  <= 1'b0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      ack_q  <= ack_n;
      act_q  <= act_n;
      ovf_q  <= ovf_n;
      done_q <= act_n && (pend_n == '0) && !req_lvl_n_i && !ack_n;
    end
  end

  assign ack_o    = ack_q;
  assign pend_o   = pend_q;
  assign done_o   = done_q;
  assign ovf_o    = ovf_q;
  assign active_o = act_q;
endmodule

// File: rtl/pt_pair_classifier.sv
module pt_pair_classifier
  import pt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      asrt_evt_i,
  input  logic      p1_i,
  output pair_cls_e cls_o,
  output logic      perr_o
);
  logic      first_q;
  logic      ref_q;
  logic      seen_q;
  logic      perr_q;
  pair_cls_e cls_q;
  logic      toggled;

  assign toggled = (p1_i != ref_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
      ref_q   <= 1'b0;
      seen_q  <= 1'b0;
      perr_q  <= 1'b0;
      cls_q   <= PAIR_INVALID;
    end else if (start_i) begin
      first_q <= 1'b1;
      seen_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else if (asrt_evt_i) begin
      ref_q <= p1_i;
      if (first_q) begin
        first_q <= 1'b0;
        cls_q   <= PAIR_VALID;
        seen_q  <= 1'b0;
      end else if (toggled) begin
        if (cls_q == PAIR_INVALID) seen_q <= 1'b1;
      end else begin
        cls_q <= flip_cls(cls_q);
        if (cls_q == PAIR_VALID) begin
          seen_q <= 1'b0;
        end else if (!seen_q) begin
          perr_q <= 1'b1;
        end
      end
    end
  end

  assign cls_o  = cls_q;
  assign perr_o = perr_q;
endmodule

// File: rtl/pt_word_assembler.sv
module pt_word_assembler #(
  parameter int DW = 16,
  localparam int WW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          asrt_evt_i,
  input  logic          neg_evt_i,
  input  logic          pair_ok_i,
  input  logic [DW-1:0] data_i,
  output logic [WW-1:0] word_o,
  output logic          vld_o
);
  logic [DW-1:0] hi_q;
  logic [WW-1:0] word_q;
  logic          vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (asrt_evt_i) hi_q <= data_i;
      if (neg_evt_i && pair_ok_i) begin
        word_q <= {hi_q, data_i};
        vld_q  <= 1'b1;
      end
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/pt_rx.sv
module pt_rx
  import pt_pkg::*;
#(
  parameter int DW       = 16,
  parameter int MAX_PEND = 15,
  localparam int CNT_W   = $clog2(MAX_PEND + 1),
  localparam int WW      = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             req_evt_i,
  input  logic [DW-1:0]    data_i,
  input  logic             p1_i,
  input  logic             ack_en_i,
  output logic             ack_o,
  output logic [CNT_W-1:0] pend_o,
  output logic             done_o,
  output logic [WW-1:0]    word_o,
  output logic             word_vld_o,
  output logic             proto_err_o,
  output logic             ovf_o
);
  logic      req_q;
  logic      asrt_evt, neg_evt;
  logic      active;
  pair_cls_e cls;

  assign asrt_evt = req_evt_i && !req_q;
  assign neg_evt  = req_evt_i && req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_q ^ req_evt_i;
  end

  pt_ack_tracker #(.MAX_PEND(MAX_PEND), .CNT_W(CNT_W)) u_ack (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .req_evt_i  (req_evt_i),
    .req_lvl_n_i(req_q ^ req_evt_i),
    .ack_en_i   (ack_en_i),
    .ack_o      (ack_o),
    .pend_o     (pend_o),
    .done_o     (done_o),
    .ovf_o      (ovf_o),
    .active_o   (active)
  );

  pt_pair_classifier u_cls (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .asrt_evt_i(asrt_evt),
    .p1_i      (p1_i),
    .cls_o     (cls),
    .perr_o    (proto_err_o)
  );

  pt_word_assembler #(.DW(DW)) u_asm (
    .clk       (clk),
    .rst       (rst),
    .asrt_evt_i(asrt_evt),
    .neg_evt_i (neg_evt),
    .pair_ok_i (active && (cls == PAIR_VALID)),
    .data_i    (data_i),
    .word_o    (word_o),
    .vld_o     (word_vld_o)
  );
endmodule

// File: rtl/pt_rx_chk.sv
module pt_rx_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             req_evt_i,
  input logic             ack_en_i,
  input logic             ack_o,
  input logic [CNT_W-1:0] pend_o,
  input logic             done_o,
  input logic             word_vld_o,
  input logic             proto_err_o,
  input logic             ovf_o
);
  // R2
  ack_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o != $past(ack_o)) |-> ($past(pend_o) != '0 && $past(ack_en_i)));

  // R3
  pend_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(req_evt_i) && !$past(ack_en_i)) |-> $stable(pend_o));

  // R4
  done_bal_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pend_o == '0 && !ack_o));

  // R5
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  // R9
  perr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(proto_err_o) && !$past(start_i)) |-> proto_err_o);

  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf_o) && !$past(start_i)) |-> ovf_o);
endmodule

bind pt_rx pt_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .req_evt_i  (req_evt_i),
  .ack_en_i   (ack_en_i),
  .ack_o      (ack_o),
  .pend_o     (pend_o),
  .done_o     (done_o),
  .word_vld_o (word_vld_o),
  .proto_err_o(proto_err_o),
  .ovf_o      (ovf_o)
);

// File: tb/pt_rx_tb.sv
module pt_rx_tb;
  localparam int DW = 16;
  localparam int MAXP = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, req_evt_i = 1'b0, p1_i = 1'b0, ack_en_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        ack_o, done_o, word_vld_o, proto_err_o, ovf_o;
  logic [3:0]  pend_o;
  logic [31:0] word_o;

  int errs = 0, checks = 0;
  bit finished = 0;

  // bench model state
  int   m_pend = 0;
  bit   m_ack = 0, m_req = 0, m_act = 0, m_ovf = 0, m_perr = 0;
  bit   m_first = 1, m_ref = 0, m_cls = 0, m_seen = 0;
  bit   m_vld = 0;
  logic [15:0] m_hi = '0;
  logic [31:0] m_word = '0;

  always #4 clk = ~clk;

  pt_rx #(.DW(DW), .MAX_PEND(MAXP)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .req_evt_i(req_evt_i),
    .data_i(data_i), .p1_i(p1_i), .ack_en_i(ack_en_i), .ack_o(ack_o),
    .pend_o(pend_o), .done_o(done_o), .word_o(word_o),
    .word_vld_o(word_vld_o), .proto_err_o(proto_err_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_done(input bit act, input int pend, input bit rq, input bit ak);
    return act && pend == 0 && !rq && !ak;
  endfunction

  task automatic model(input bit evt, input logic [15:0] d, input bit p, input bit en, input bit st);
    bit fire;
    fire = en && m_pend > 0;
    m_vld = 0;
    if (st) begin
      m_act = 1; m_first = 1; m_seen = 0; m_perr = 0; m_ovf = 0;
    end
    if (evt && !m_req && !st) begin
      m_hi = d;
      if (m_first) begin
        m_first = 0; m_cls = 1; m_seen = 0;
      end else if (p != m_ref) begin
        if (!m_cls) m_seen = 1;
      end else if (m_cls) begin
        m_cls = 0; m_seen = 0;
      end else begin
        m_cls = 1;
        if (!m_seen) m_perr = 1;
      end
      m_ref = p;
    end
    if (evt && m_req && m_act && m_cls) begin
      m_vld = 1; m_word = {m_hi, d};
    end
    if (evt && m_req) m_hi = m_hi;
    if (evt) begin
      if (m_pend == MAXP && !fire) m_ovf = 1;
      else m_pend++;
    end
    if (fire) begin m_pend--; m_ack = ~m_ack; end
    if (evt) m_req = ~m_req;
  endtask

  task automatic step(input bit evt, input logic [15:0] d, input bit p, input bit en,
                      input bit st, input string wtag);
    req_evt_i = evt; data_i = d; p1_i = p; ack_en_i = en; start_i = st;
    @(posedge clk);
    model(evt, d, p, en, st);
    @(negedge clk);
    req_evt_i = 0; start_i = 0;
    chk(ack_o == m_ack, "R2 ack level", ack_o, m_ack);
    chk(pend_o == 4'(m_pend), "R3 pending", pend_o, m_pend);
    chk(done_o == exp_done(m_act, m_pend, m_req, m_ack), "R4 done", done_o,
        exp_done(m_act, m_pend, m_req, m_ack));
    chk(word_vld_o == m_vld, wtag, word_vld_o, m_vld);
    if (m_vld && word_vld_o) chk(word_o == m_word, "R5 word data", word_o, m_word);
    chk(proto_err_o == m_perr, "R9 proto_err", proto_err_o, m_perr);
    chk(ovf_o == m_ovf, "R10 ovf", ovf_o, m_ovf);
  endtask

  task automatic send_pair(input bit p, input logic [15:0] d0, input logic [15:0] d1,
                           input bit en, input int gap, input string tag);
    step(1, d0, p, en, 0, tag);
    for (int i = 0; i < gap; i++) step(0, $urandom, $urandom, en, 0, tag);
    step(1, d1, $urandom, en, 0, tag);
    for (int i = 0; i < gap; i++) step(0, $urandom, $urandom, en, 0, tag);
  endtask

  task automatic drain();
    for (int i = 0; i < MAXP + 3; i++) step(0, 0, 0, 1, 0, "R5 idle");
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!ack_o && !word_vld_o && !done_o && pend_o == 0 && !proto_err_o && !ovf_o,
        "R1 reset outputs", {ack_o, word_vld_o, done_o, pend_o, proto_err_o, ovf_o}, 0);

    // R11 traffic before start: acked, no word, no done
    send_pair(1, 16'h1111, 16'h2222, 1, 0, "R11 no word before start");
    drain();
    chk(done_o == 0, "R11 done before start", done_o, 0);

    // R6 first pair after start is valid even with unchanged p1
    step(0, 0, 0, 1, 1, "R6 start");
    send_pair(1, 16'hA1A2, 16'hB1B2, 1, 0, "R6 first pair valid");
    // R7 toggled pair keeps valid
    send_pair(0, 16'hC1C2, 16'hD1D2, 1, 1, "R7 toggle keeps valid");
    // R8 missing toggle -> invalid
    send_pair(0, 16'hE1E2, 16'hF1F2, 1, 0, "R8 reversal to invalid");
    // R7 toggle while invalid -> still invalid, no word
    send_pair(1, 16'h0102, 16'h0304, 1, 0, "R7 invalid stays invalid");
    // R8 missing toggle -> valid again, no error (toggle seen)
    send_pair(1, 16'h0506, 16'h0708, 1, 0, "R8 reversal back to valid");
    drain();
    chk(done_o == 1, "R4 done after balanced phase", done_o, 1);

    // R9 invalid stretch without a phase change
    step(0, 0, 0, 1, 1, "R9 start");
    send_pair(0, 16'h1234, 16'h5678, 1, 0, "R9 pair a");
    send_pair(0, 16'h9ABC, 16'hDEF0, 1, 0, "R9 pair b invalid");
    send_pair(0, 16'h1357, 16'h2468, 1, 0, "R9 pair c back valid");
    chk(proto_err_o == 1, "R9 error flagged", proto_err_o, 1);
    step(0, 0, 0, 1, 1, "R9 clear by start");
    chk(proto_err_o == 0, "R9 cleared", proto_err_o, 0);

    // R10 overrun with ACK held off
    for (int i = 0; i < MAXP + 2; i++) step(1, $urandom, $urandom, 0, 0, "R10 fill");
    chk(ovf_o == 1 && pend_o == 4'(MAXP), "R10 saturate", {ovf_o, pend_o}, {1'b1, 4'(MAXP)});
    drain();
    if (m_req) step(1, 0, 0, 1, 0, "R10 close");
    drain();

    // random phases
    for (int r = 0; r < 6; r++) begin
      step(0, 0, 0, 1, 1, "R6 random start");
      for (int k = 0; k < 60; k++) begin
        bit p;
        p = (($urandom % 4) != 0) ? ~m_ref : m_ref;
        send_pair(p, $urandom, $urandom, ($urandom % 5) != 0, $urandom % 3, "R7/R8 random pair");
      end
      drain();
      chk(done_o == 1, "R4 done after random phase", done_o, 1);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule